// File: doc/BRIEF.md
# UART Receive Character Queue

This block holds the characters a UART receiver has assembled. Each character is kept together with four error flags, and software reads them back one at a time through the data register. The characters come from the serial receiver or from the loopback path, and the block does not tell the two apart. It keeps registered full and empty flags and a can-accept indication, which is the inverse of full. It also raises a receive-level interrupt status bit using exact comparisons against a programmable trigger level.

A line-control enable input selects between two modes:

- **Queue mode:** the effective depth is `DEPTH` (16 by default).
- **Character mode:** the effective depth is one entry.

Any change of that enable flushes the queue. When software reads a character, that character's error flags are copied into a receive status register. A write strobe clears that register. A character that arrives while the queue is full is discarded and raises the overrun status bit.

Top module: `uart_rx_queue`

## Requirements
- R1: With `fifo_en`=1 the queue accepts `DEPTH` characters; with `fifo_en`=0 it accepts one. `can_accept` is low exactly when the count equals the current depth.
- R2: Characters leave in arrival order. A read (`pop`) places the oldest character on `rd_data` one cycle later. The error bits travel with it, with bit 0 framing, bit 1 parity, bit 2 break and bit 3 overrun.
- R3: `full` equals (count == current depth) and `empty` equals (count == 0). Both are registered and update one cycle after the push, read or flush.
- R4: A push while full is discarded and leaves the stored characters unchanged. It sets `status_err[3]` (overrun) one cycle later.
- R5: A read while empty leaves the count, pointer and flags unchanged. It still returns the entry at the read slot on `rd_data`.
- R6: After a push, if the new count equals the trigger level, `rx_irq` is set.
- R7: After a read, if the resulting count plus one equals the trigger level, `rx_irq` is cleared. This also applies to a read while empty. A set from a push in the same cycle wins over the clear.
- R8: A read loads `status_err` with the error bits of the character read. `stat_clr` zeroes it and takes priority over the load. The overrun from a discarded push is still ORed in.
- R9: A change of `fifo_en` against the mode in force flushes the queue: count and pointer go to 0, `empty`=1 and `full`=0. A push or read in that cycle is ignored, and `rx_irq` is unchanged.
- R10: After synchronous reset the block is in character mode with `empty`=1, `full`=0, `rx_irq`=0, `status_err`=0, `rd_data`=0 and trigger level 1.
- R11: A push and a read in the same cycle are both honoured when neither is blocked. The count is then unchanged.
- R12: `trig_we` loads the trigger level from `trig_level`. The new level applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Line-control queue enable (1 = DEPTH entries, 0 = one entry) |
| trig_we | input | 1 | Trigger level write strobe |
| trig_level | input | CNT_W | New trigger level |
| push_valid | input | 1 | Incoming character strobe |
| push_data | input | DATA_W | Incoming character |
| push_err | input | 4 | Incoming error flags {overrun, break, parity, framing} |
| can_accept | output | 1 | Another character can be stored |
| pop | input | 1 | Data register read strobe |
| rd_data | output | DATA_W | Character returned by the last read |
| stat_clr | input | 1 | Write to receive status register (clears it) |
| status_err | output | 4 | Receive status error bits |
| full | output | 1 | Queue full flag |
| empty | output | 1 | Queue empty flag |
| rx_irq | output | 1 | Receive-level interrupt status |

## Verification
Every output of this block is a register, so `rd_data`, `status_err`, `full`, `empty`, `can_accept` and `rx_irq` all reflect a push, read, clear, trigger write or mode change exactly one clock later. The bench drives each stimulus on the falling edge and advances its model by the same single step. It then compares every output 1 ns after the following rising edge, so no check looks before or after the cycle the result is due. Same-cycle combinations (push with read, full with push, empty with read, a mode change with traffic) use the same one-cycle window.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ERR_W      = 4;
  localparam int ERR_FRAME  = 0;
  localparam int ERR_PARITY = 1;
  localparam int ERR_BREAK  = 2;
  localparam int ERR_OVR    = 3;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int W      = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Write port, no reset so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port, read-before-write
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = rxq_pkg::ERR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] werr,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          clr,
  input  logic          drop,
  output logic [EW-1:0] status
);
  logic [EW-1:0] err_mem [DEPTH];
  logic [EW-1:0] status_n;

  // Error flags in flops so status loads in the same cycle as the data read
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) err_mem[i] <= '0;
    end else if (we) begin
      err_mem[waddr] <= werr;
    end
  end

  always_comb begin
    if (clr)     status_n = '0;
    else if (re) status_n = err_mem[raddr];
    else         status_n = status;
    if (drop) status_n[rxq_pkg::ERR_OVR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_n;
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (clr && !drop) |=> (status == '0));  // R8
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (rst)
    drop |=> status[rxq_pkg::ERR_OVR]);  // R4
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          trig_we,
  input  logic [CW-1:0] trig_val,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          drop,
  output logic          full,
  output logic          empty,
  output logic          irq
);
  logic          fen_q;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] cnt_q, trig_q;
  logic [CW-1:0] depth_c, cnt_ap, cnt_n;
  logic [AW-1:0] mask_c;
  logic          flush, room, push_ok, pop_ok;

  assign flush   = fifo_en ^ fen_q;
  assign depth_c = fen_q ? CW'(DEPTH) : CW'(1);
  assign mask_c  = fen_q ? AW'(DEPTH - 1) : '0;
  assign room    = cnt_q < depth_c;
  assign push_ok = push_req && !flush && room;
  assign pop_ok  = pop_req && !flush && (cnt_q != '0);
  assign drop    = push_req && !flush && !room;
  assign cnt_ap  = cnt_q - CW'(pop_ok);
  assign cnt_n   = cnt_ap + CW'(push_ok);

  assign we    = push_ok;
  assign waddr = (ptr_q + cnt_q[AW-1:0]) & mask_c;
  assign re    = pop_req && !flush;
  assign raddr = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q  <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      trig_q <= CW'(1);
      full   <= 1'b0;
      empty  <= 1'b1;
      irq    <= 1'b0;
    end else begin
      if (trig_we) trig_q <= trig_val;
      if (flush) begin
        fen_q <= fifo_en;
        ptr_q <= '0;
        cnt_q <= '0;
        full  <= 1'b0;
        empty <= 1'b1;
      end else begin
        cnt_q <= cnt_n;
        ptr_q <= (ptr_q + AW'(pop_ok)) & mask_c;
        full  <= (cnt_n == depth_c);
        empty <= (cnt_n == '0);
        if (push_ok && cnt_n == trig_q)              irq <= 1'b1;
        else if (re && (cnt_ap + CW'(1)) == trig_q)  irq <= 1'b0;
      end
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));  // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= depth_c);  // R1
  AST_CHAR_ONE: assert property (@(posedge clk) disable iff (rst)
    (!fen_q && !empty) |-> full);  // R1
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !full));  // R9
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && !pop_req && !flush) |=> full);  // R4
  AST_BOTH_KEEP_CNT: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !flush && !full && !empty) |=> $stable(cnt_q));  // R11
  AST_IRQ_AT_TRIG: assert property (@(posedge clk) disable iff (rst)
    (push_req && !pop_req && !flush && !full && (cnt_q + CW'(1)) == trig_q) |=> irq);  // R6
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int EW    = rxq_pkg::ERR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              trig_we,
  input  logic [CNT_W-1:0]  trig_level,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic [EW-1:0]     push_err,
  output logic              can_accept,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_clr,
  output logic [EW-1:0]     status_err,
  output logic              full,
  output logic              empty,
  output logic              rx_irq
);
  logic          we, re, drop;
  logic [AW-1:0] waddr, raddr;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_we(trig_we),
    .trig_val(trig_level), .push_req(push_valid), .pop_req(pop),
    .we(we), .waddr(waddr), .re(re), .raddr(raddr), .drop(drop),
    .full(full), .empty(empty), .irq(rx_irq)
  );

  rxq_store #(.DEPTH(DEPTH), .W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(push_data),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .werr(push_err),
    .re(re), .raddr(raddr), .clr(stat_clr), .drop(drop), .status(status_err)
  );

  assign can_accept = !full;

  AST_ACCEPT_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    (!can_accept && push_valid && !pop && fifo_en == $past(fifo_en)) |=> !can_accept);  // R1
endmodule

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic fifo_en = 0, trig_we = 0, push_valid = 0, pop = 0, stat_clr = 0;
  logic [CW-1:0] trig_level = '0;
  logic [7:0] push_data = '0;
  logic [3:0] push_err = '0;
  logic can_accept, full, empty, rx_irq;
  logic [7:0] rd_data;
  logic [3:0] status_err;

  always #4 clk = ~clk;

  uart_rx_queue u0 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_we(trig_we), .trig_level(trig_level),
    .push_valid(push_valid), .push_data(push_data), .push_err(push_err),
    .can_accept(can_accept), .pop(pop), .rd_data(rd_data), .stat_clr(stat_clr),
    .status_err(status_err), .full(full), .empty(empty), .rx_irq(rx_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R10";

  // reference model state
  logic [7:0] m_dat [DEPTH];
  logic [3:0] m_err [DEPTH];
  int m_cnt = 0, m_ptr = 0, m_trig = 1;
  bit m_fen = 0, m_irq = 0;
  logic [7:0] m_rd = 0;
  logic [3:0] m_st = 0;

  function automatic int cur_depth();
    return m_fen ? DEPTH : 1;
  endfunction

  task automatic check(input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  task automatic check_all();
    check("rd_data", rd_data, m_rd);
    check("status_err", status_err, m_st);
    check("full", full, m_cnt == cur_depth());
    check("empty", empty, m_cnt == 0);
    check("can_accept", can_accept, m_cnt != cur_depth());
    check("rx_irq", rx_irq, m_irq);
  endtask

  task automatic model(input bit pu, input [7:0] d, input [3:0] e, input bit po,
                       input bit cl, input bit fe, input bit tw, input int tv);
    int old_trig = m_trig;
    if (tw) m_trig = tv;
    if (fe != m_fen) begin
      m_fen = fe; m_cnt = 0; m_ptr = 0;
      if (cl) m_st = 0;
    end else begin
      int dep = cur_depth();
      bit pop_ok = po && m_cnt > 0;
      bit push_ok = pu && m_cnt < dep;
      bit drop = pu && !push_ok;
      int cap;
      if (po) m_rd = m_dat[m_ptr];
      if (cl) m_st = 0; else if (po) m_st = m_err[m_ptr];
      if (drop) m_st[3] = 1'b1;
      if (push_ok) begin
        m_dat[(m_ptr + m_cnt) & (dep - 1)] = d;
        m_err[(m_ptr + m_cnt) & (dep - 1)] = e;
      end
      cap = m_cnt - int'(pop_ok);
      m_cnt = cap + int'(push_ok);
      m_ptr = (m_ptr + int'(pop_ok)) & (dep - 1);
      if (push_ok && m_cnt == old_trig) m_irq = 1;
      else if (po && cap + 1 == old_trig) m_irq = 0;
    end
  endtask

  task automatic step(input bit pu, input [7:0] d, input [3:0] e, input bit po,
                      input bit cl, input bit fe, input bit tw, input int tv);
    @(negedge clk);
    push_valid = pu; push_data = d; push_err = e; pop = po; stat_clr = cl;
    fifo_en = fe; trig_we = tw; trig_level = CW'(tv);
    model(pu, d, e, po, cl, fe, tw, tv);
    @(posedge clk); #1;
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    cur_req = "R10"; check_all();

    // character mode: one entry, trigger 1
    cur_req = "R1";  step(1, 8'hA5, 4'b0001, 0, 0, 0, 0, 0);
    cur_req = "R4";  step(1, 8'h5A, 4'b0000, 0, 0, 0, 0, 0);
    cur_req = "R7";  step(0, 0, 0, 1, 0, 0, 0, 0);
    cur_req = "R5";  step(0, 0, 0, 1, 0, 0, 0, 0);
    cur_req = "R8";  step(0, 0, 0, 0, 1, 0, 0, 0);

    // queue mode, trigger 4
    cur_req = "R9";  step(0, 0, 0, 0, 0, 1, 1, 4);
    cur_req = "R12";
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 4'(i), 0, 0, 1, 0, 0);
    cur_req = "R4";  step(1, 8'hEE, 4'b0110, 0, 0, 1, 0, 0);
    cur_req = "R11"; step(1, 8'h77, 4'b0010, 1, 0, 1, 0, 0);
    cur_req = "R11"; step(1, 8'h78, 4'b0100, 1, 0, 1, 0, 0);
    cur_req = "R2";
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 0, 1, 0, 0);
    cur_req = "R6";
    for (int i = 0; i < 6; i++) step(1, 8'(8'h40 + i), 4'b1000, 0, 0, 1, 0, 0);
    cur_req = "R9";  step(1, 8'h99, 0, 1, 1, 0, 0, 0);
    cur_req = "R9";  step(1, 8'h9A, 0, 0, 0, 1, 0, 0);
    cur_req = "R3";  step(1, 8'h9B, 0, 0, 0, 1, 0, 0);

    // constrained random traffic
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      bit fe = m_fen;
      if ($urandom % 300 == 0) fe = !fe;
      step(($urandom % 100) < 55, 8'($urandom), 4'($urandom), ($urandom % 100) < 45,
           ($urandom % 100) < 4, fe, ($urandom % 100) < 3, int'($urandom % (DEPTH + 1)));
    end
    finish_run();
  end
endmodule